// File: doc/BRIEF.md
# Outstanding-Limited Address Remapping Stage

This block sits at the entry of one master port of a memory-cube interconnect. A read or write request is let through only while the number of transactions already in flight on the port is below a parameterised cap. Each completion (the last read beat or a write response) retires one transaction. Requests that arrive at the cap wait until a completion frees a slot.

The block also changes the layout of each admitted address. The address is read as three movable fields (vault, bank within the vault, and row/column) above a fixed offset field at the bottom. A runtime mode selects which of the six orderings of those three fields the incoming address uses. The block rebuilds the address into one fixed layout and forwards it with the decoded vault index. The active mode is taken from the mode input only while the port is idle, so every in-flight transaction shares one mapping.

The request path is combinational. The only state is the in-flight counter and the active mode register.

Top module: `addr_remap_stage`

## Requirements
- R1: A request is accepted in a cycle when `req_valid`, `fwd_ready` and count < MAX_OUT all hold. `req_ready` equals `fwd_ready` while count < MAX_OUT and is 0 otherwise. `fwd_valid` equals `req_valid` while count < MAX_OUT and is 0 otherwise. `fwd_write` follows `req_write`.
- R2: Once MAX_OUT (default 4) requests have been accepted with none retired, `req_ready` and `fwd_valid` stay low. One completion reopens admission from the next cycle.
- R3: An accepted request increments the count and `cpl_valid` decrements it. If both occur in the same cycle, the count does not change.
- R4: A `cpl_valid` pulse while the count is zero is ignored. The count stays zero and MAX_OUT new requests are still needed to reach the cap.
- R5: `fwd_addr` is always laid out as {RC[13:0], BA[2:0], VA[3:0], OF[7:0]} (RC at bits 28:15, BA at 14:12, VA at 11:8, OF at 7:0). The offset bits [7:0] pass through unchanged in every mode.
- R6: Mode values 0 to 5 give the incoming field order above OF, listed from the most significant field down: 0 = RC,BA,VA; 1 = RC,VA,BA; 2 = BA,RC,VA; 3 = BA,VA,RC; 4 = VA,RC,BA; 5 = VA,BA,RC.
- R7: Mode values 6 and 7 act as mode 0.
- R8: The active mode is loaded from `mode_sel` on each clock edge at which the count is zero. The new mode applies from the following cycle. A change of `mode_sel` while transactions are outstanding has no effect until the count returns to zero.
- R9: `fwd_vault` equals the VA field of the remapped address.
- R10: After reset the count is zero, the active mode is 0, and `req_ready` follows `fwd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Requested address field ordering |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | Incoming request accepted |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 29 | Incoming address in the active ordering |
| cpl_valid | input | 1 | One transaction completed (last read beat or write response) |
| fwd_valid | output | 1 | Remapped request valid |
| fwd_ready | input | 1 | Downstream can take the request |
| fwd_write | output | 1 | Write flag of the forwarded request |
| fwd_addr | output | 29 | Address in the fixed RC,BA,VA,OF layout |
| fwd_vault | output | 4 | Decoded vault index |

## Verification
Admission and retirement can land in the same cycle. The bench provokes this by raising `cpl_valid` one cycle below the cap while a request is being accepted. It then judges the result from the ports: admission must still be open in the next cycle, and exactly one more acceptance must close it.

A mode change can also arrive while the port is busy. The bench changes `mode_sel` with the port at its cap and checks that the remapped address keeps the old ordering. It then checks that the new ordering appears only one cycle after the count has drained to zero.

// File: rtl/addr_remap_stage.sv
module addr_remap_stage #(
  parameter int MAX_OUT = 4,
  parameter int OF_W    = 8,
  parameter int VA_W    = 4,
  parameter int BA_W    = 3,
  parameter int RC_W    = 14
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [2:0]                            mode_sel,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic                                  req_write,
  input  logic [OF_W+VA_W+BA_W+RC_W-1:0]        req_addr,
  input  logic                                  cpl_valid,
  output logic                                  fwd_valid,
  input  logic                                  fwd_ready,
  output logic                                  fwd_write,
  output logic [OF_W+VA_W+BA_W+RC_W-1:0]        fwd_addr,
  output logic [VA_W-1:0]                       fwd_vault
);
  localparam int ADDR_W = OF_W + VA_W + BA_W + RC_W;
  localparam int CNT_W  = $clog2(MAX_OUT + 1);
  localparam int POS_W  = $clog2(ADDR_W);

  logic [CNT_W-1:0] inflight;
  logic [2:0]       mode_q;
  logic [2:0]       mode_ok;
  logic             admit, take, retire;
  logic [POS_W-1:0] va_pos, ba_pos, rc_pos;
  logic [VA_W-1:0]  va_f;
  logic [BA_W-1:0]  ba_f;
  logic [RC_W-1:0]  rc_f;

  assign admit     = inflight < CNT_W'(MAX_OUT);
  assign req_ready = fwd_ready & admit;
  assign fwd_valid = req_valid & admit;
  assign fwd_write = req_write;
  assign take      = req_valid & req_ready;
  assign retire    = cpl_valid & (inflight != '0);
  assign mode_ok   = (mode_sel > 3'd5) ? 3'd0 : mode_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      inflight <= '0;
    else if (take != retire)
      inflight <= take ? inflight + 1'b1 : inflight - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      mode_q <= 3'd0;
    else if (inflight == '0)
      mode_q <= mode_ok;

  always_comb begin
    case (mode_q)
      3'd1: begin
        ba_pos = POS_W'(OF_W);
        va_pos = POS_W'(OF_W + BA_W);
        rc_pos = POS_W'(OF_W + BA_W + VA_W);
      end
      3'd2: begin
        va_pos = POS_W'(OF_W);
        rc_pos = POS_W'(OF_W + VA_W);
        ba_pos = POS_W'(OF_W + VA_W + RC_W);
      end
      3'd3: begin
        rc_pos = POS_W'(OF_W);
        va_pos = POS_W'(OF_W + RC_W);
        ba_pos = POS_W'(OF_W + RC_W + VA_W);
      end
      3'd4: begin
        ba_pos = POS_W'(OF_W);
        rc_pos = POS_W'(OF_W + BA_W);
        va_pos = POS_W'(OF_W + BA_W + RC_W);
      end
      3'd5: begin
        rc_pos = POS_W'(OF_W);
        ba_pos = POS_W'(OF_W + RC_W);
        va_pos = POS_W'(OF_W + RC_W + BA_W);
      end
      default: begin
        va_pos = POS_W'(OF_W);
        ba_pos = POS_W'(OF_W + VA_W);
        rc_pos = POS_W'(OF_W + VA_W + BA_W);
      end
    endcase
  end

  assign va_f      = req_addr[va_pos +: VA_W];
  assign ba_f      = req_addr[ba_pos +: BA_W];
  assign rc_f      = req_addr[rc_pos +: RC_W];
  assign fwd_addr  = {rc_f, ba_f, va_f, req_addr[OF_W-1:0]};
  assign fwd_vault = va_f;

  assert_cap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == CNT_W'(MAX_OUT)) |-> (!req_ready && !fwd_valid));
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (inflight != CNT_W'(MAX_OUT)));
  assert_both_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cpl_valid && inflight != '0) |=> $stable(inflight));
  assert_idle_cpl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == '0 && !take) |=> (inflight == '0));
  assert_offset_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_addr[OF_W-1:0] == req_addr[OF_W-1:0]);
  assert_mode_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q <= 3'd5);
  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight != '0) |=> $stable(mode_q));
  assert_vault_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_vault == fwd_addr[OF_W +: VA_W]);
endmodule

// File: tb/test_addr_remap_stage.sv
module test_addr_remap_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic        req_valid = 1'b0, req_write = 1'b0, cpl_valid = 1'b0, fwd_ready = 1'b0;
  logic [28:0] req_addr = '0;
  logic        req_ready, fwd_valid, fwd_write;
  logic [28:0] fwd_addr;
  logic [3:0]  fwd_vault;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  addr_remap_stage i_addr_remap_stage (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .cpl_valid(cpl_valid), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
    .fwd_write(fwd_write), .fwd_addr(fwd_addr), .fwd_vault(fwd_vault));

  // {mode, rc, ba, va, of}
  localparam logic [31:0] VEC [8] = '{
    {3'd0, 14'h2A5B, 3'd5, 4'hC, 8'h3D},
    {3'd1, 14'h1234, 3'd2, 4'h7, 8'hF0},
    {3'd2, 14'h3FFF, 3'd1, 4'h0, 8'h01},
    {3'd3, 14'h0001, 3'd6, 4'h9, 8'hAA},
    {3'd4, 14'h2222, 3'd3, 4'hF, 8'h55},
    {3'd5, 14'h1C3A, 3'd7, 4'h4, 8'h80},
    {3'd3, 14'h3001, 3'd0, 4'hE, 8'h7F},
    {3'd5, 14'h0F0F, 3'd4, 4'h1, 8'h00}};

  function automatic logic [28:0] compose(input logic [2:0] m, input logic [13:0] rc,
                                          input logic [2:0] ba, input logic [3:0] va,
                                          input logic [7:0] of);
    case (m)
      3'd1:    return {rc, va, ba, of};
      3'd2:    return {ba, rc, va, of};
      3'd3:    return {ba, va, rc, of};
      3'd4:    return {va, rc, ba, of};
      3'd5:    return {va, ba, rc, of};
      default: return {rc, ba, va, of};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drain(input int n);
    cpl_valid = 1'b1;
    repeat (n) @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    fwd_ready = 1'b1;
    #1;
    chk("R10 ready after reset", req_ready, 1);
    chk("R10 no valid when idle", fwd_valid, 0);

    // table walk: remap in every mode, count stays zero
    fwd_ready = 1'b0;
    req_valid = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      mode_sel = VEC[i][31:29];
      @(negedge clk);
      req_addr = compose(VEC[i][31:29], VEC[i][28:15], VEC[i][14:12], VEC[i][11:8], VEC[i][7:0]);
      #1;
      chk("R6 R5 remapped address", fwd_addr, VEC[i][28:0]);
      chk("R9 vault index", fwd_vault, VEC[i][11:8]);
    end

    // invalid modes fall back to mode 0
    for (int m = 6; m < 8; m++) begin
      @(negedge clk);
      mode_sel = 3'(m);
      @(negedge clk);
      req_addr = compose(3'd0, 14'h1A2B, 3'd6, 4'h5, 8'hC3);
      #1;
      chk("R7 invalid mode acts as 0", fwd_addr, {14'h1A2B, 3'd6, 4'h5, 8'hC3});
    end

    // downstream not ready: nothing accepted
    @(negedge clk);
    mode_sel = 3'd0;
    req_write = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 ready low without fwd_ready", req_ready, 0);
    chk("R1 valid passes", fwd_valid, 1);
    chk("R1 write flag", fwd_write, 1);

    // fill to the cap
    fwd_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 below cap still open", req_ready, 1);
    @(negedge clk);
    chk("R2 ready low at cap", req_ready, 0);
    chk("R2 valid low at cap", fwd_valid, 0);

    // one completion reopens
    cpl_valid = 1'b1;
    @(negedge clk);
    chk("R2 reopen after completion", req_ready, 1);
    // accept + completion in the same cycle (count 3 stays 3)
    @(negedge clk);
    cpl_valid = 1'b0;
    chk("R3 simultaneous keeps count", req_ready, 1);
    @(negedge clk);
    chk("R3 one more closes", req_ready, 0);

    // mode change while busy
    req_valid = 1'b1;
    fwd_ready = 1'b0;
    mode_sel = 3'd3;
    req_addr = compose(3'd0, 14'h0ABC, 3'd2, 4'hD, 8'h11);
    repeat (2) @(negedge clk);
    chk("R8 mode frozen while busy", fwd_addr, {14'h0ABC, 3'd2, 4'hD, 8'h11});
    drain(4);
    req_addr = compose(3'd3, 14'h0ABC, 3'd2, 4'hD, 8'h11);
    #1;
    chk("R8 new mode not yet active", fwd_addr == {14'h0ABC, 3'd2, 4'hD, 8'h11}, 0);
    @(negedge clk);
    chk("R8 new mode after idle edge", fwd_addr, {14'h0ABC, 3'd2, 4'hD, 8'h11});

    // completions at zero are ignored
    req_valid = 1'b0;
    drain(2);
    req_valid = 1'b1;
    fwd_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 idle completion ignored", req_ready, 1);
    @(negedge clk);
    chk("R4 cap reached after four", req_ready, 0);
    req_valid = 1'b0;
    drain(4);
    #1;
    chk("R10 drained port reopens", req_ready, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule